// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a successive-approximation analog-to-digital converter. It drives a trial code to an external DAC, and at the end of each trial it samples one comparator bit. The highest bit is resolved first and the lowest last. The block sits between the control logic, which issues a convert command, and the analog front end, which holds the comparator and the DAC.

The convert command has two roles. While it is high, the sequencer is held idle and cleared. When it falls, after it has been high for long enough, a conversion begins. The result appears in two forms. The first is a parallel word in complementary sense, where logic 0 means a true bit; it can optionally carry an inverted top bit to give two's-complement coding. The second is an NRZ serial stream, top bit first, with one clock pulse per resolved bit. A status output is high for the whole conversion.

A trim input shortens the conversion to fewer bits. It is sampled when the conversion starts. The bits that are not resolved stay cleared.

Top module: `sar_convert_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no conversion yet, `status` and `ser_clk` are 0, `ser_data` is 1, `dac_code` is all zeros and `data_n` is all ones (with `msb_flip` 0).
- R2: A conversion starts only when `convert` is sampled low after being sampled high on at least MIN_HIGH (default 2) consecutive clock edges. A shorter high pulse starts nothing, and `status` stays 0.
- R3: On any edge that samples `convert` high, the sequencer is cleared. From the next cycle on, `status` is 0, `dac_code` is all zeros and `data_n` is all ones. A conversion in progress is therefore aborted.
- R4: `status` goes high in the cycle after the starting edge and stays high for exactly n*TRIAL_CYC+1 cycles, where n is the resolution and TRIAL_CYC defaults to 4.
- R5: Bits are decided from bit WIDTH-1 downward. Each trial lasts TRIAL_CYC cycles. During a trial, `dac_code` is the bits already decided, OR the trial bit. `comp_in`, sampled on the edge that ends the trial, keeps the bit when it is 1 and clears it when it is 0. With an ideal comparator (input >= code), the true result is the input code with its low WIDTH-n bits cleared.
- R6: `data_n` is the bitwise complement of the true result. Bits that were not resolved read as 1.
- R7: `msb_flip` set to 1 inverts only bit WIDTH-1 of `data_n`. It acts at once and does not affect the serial output.
- R8: Every resolved bit gives one single-cycle `ser_clk` pulse while `status` is high: exactly n pulses, top bit first. During each pulse, `ser_data` holds the complement of that bit.
- R9: The resolution is n = WIDTH - min(`res_trim`, WIDTH-MIN_RES). A value above the limit gives MIN_RES bits. `res_trim` is latched when the conversion starts, and changing it during the conversion has no effect.
- R10: After a conversion completes, `data_n` and `dac_code` (which then shows the true result) hold their values until `convert` is next sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| convert | input | 1 | Convert command: high holds clear, falling edge starts |
| res_trim | input | 3 | Number of low bits to skip (clamped to WIDTH-MIN_RES) |
| msb_flip | input | 1 | Invert top bit of the parallel word |
| comp_in | input | 1 | Comparator result: 1 when input is at or above `dac_code` |
| dac_code | output | 16 | Trial code to the DAC, true sense |
| data_n | output | 16 | Complementary parallel result |
| ser_data | output | 1 | Complementary NRZ serial bit |
| ser_clk | output | 1 | One pulse per resolved serial bit |
| status | output | 1 | High while converting |

## Verification
The hardest case to reach is an abort in the middle of a conversion. `convert` has to rise after several bits have been decided but before the final trial, and the next conversion must then start from a fully cleared register. The bench starts a conversion and counts clock cycles to a point well inside the bit sequence. It raises `convert` there, checks the cleared outputs on the following cycle, and then runs a fresh conversion with a different input. It also changes `res_trim` in the middle of a conversion to show that the value latched at the start still governs it.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int unsigned clamp_u(input int unsigned val, input int unsigned hi);
    return (val > hi) ? hi : val;
  endfunction

endpackage

// File: rtl/sar_start_ctl.sv
module sar_start_ctl #(
  parameter int WIDTH    = 16,
  parameter int MIN_RES  = 12,
  parameter int MIN_HIGH = 2,
  localparam int MAX_TRIM = WIDTH - MIN_RES,
  localparam int TRIM_W   = $clog2(MAX_TRIM + 1),
  localparam int IDX_W    = $clog2(WIDTH),
  localparam int CNT_W    = $clog2(MIN_HIGH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convert,
  input  logic [TRIM_W-1:0] res_trim,
  output logic              rst_sync_n,
  output logic              start,
  output logic              hold,
  output logic [IDX_W-1:0]  stop_idx
);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] hi_cnt_q, hi_cnt_d;
  logic [IDX_W-1:0] stop_q, stop_d;
  logic             cnt_en, stop_en;

  // reset synchronizer: asserts at once, deasserts after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  // count the edges on which convert is high, saturating at MIN_HIGH
  always_comb begin
    hi_cnt_d = hi_cnt_q;
    cnt_en   = 1'b0;
    if (convert) begin
      if (hi_cnt_q != CNT_W'(MIN_HIGH)) begin
        hi_cnt_d = hi_cnt_q + CNT_W'(1);
        cnt_en   = 1'b1;
      end
    end else if (hi_cnt_q != '0) begin
      hi_cnt_d = '0;
      cnt_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  hi_cnt_q <= '0;
    else if (cnt_en)  hi_cnt_q <= hi_cnt_d;
  end

  assign start = !convert && (hi_cnt_q == CNT_W'(MIN_HIGH));
  assign hold  = convert;

  // resolution latched on the starting edge
  always_comb begin
    stop_en = start;
    stop_d  = IDX_W'(sar_pkg::clamp_u(32'(res_trim), MAX_TRIM));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stop_q <= '0;
    else if (stop_en) stop_q <= stop_d;
  end

  assign stop_idx = stop_q;

endmodule

// File: rtl/sar_trial_engine.sv
module sar_trial_engine #(
  parameter int WIDTH     = 16,
  parameter int TRIAL_CYC = 4,
  localparam int IDX_W    = $clog2(WIDTH),
  localparam int PH_W     = $clog2(TRIAL_CYC)
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             start,
  input  logic             hold,
  input  logic [IDX_W-1:0] stop_idx,
  input  logic             comp_in,
  output logic [WIDTH-1:0] sar,
  output logic [WIDTH-1:0] dac_code,
  output logic             running,
  output logic             bit_stb,
  output logic             bit_val_n
);

  import sar_pkg::*;

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);
  localparam logic [PH_W-1:0]  LAST_PH = PH_W'(TRIAL_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WIDTH-1:0] sar_q, sar_d;
  logic             ser_q, ser_d;
  logic             stb_q, stb_d;
  logic             reg_en;
  logic [WIDTH-1:0] trial_mask;

  assign trial_mask = {{(WIDTH-1){1'b0}}, 1'b1} << idx_q;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    sar_d   = sar_q;
    ser_d   = ser_q;
    stb_d   = 1'b0;
    if (hold) begin
      state_d = SEQ_IDLE;
      phase_d = '0;
      idx_d   = TOP_IDX;
      sar_d   = '0;
      ser_d   = 1'b1;
    end else if (start) begin
      state_d = SEQ_RUN;
      phase_d = '0;
      idx_d   = TOP_IDX;
      sar_d   = '0;
    end else if (state_q == SEQ_RUN) begin
      if (phase_q == LAST_PH) begin
        sar_d[idx_q] = comp_in;
        ser_d        = ~comp_in;
        stb_d        = 1'b1;
        phase_d      = '0;
        if (idx_q == stop_idx) state_d = SEQ_IDLE;
        else                   idx_d   = idx_q - IDX_W'(1);
      end else begin
        phase_d = phase_q + PH_W'(1);
      end
    end
  end

  assign reg_en = hold || start || (state_q == SEQ_RUN) || stb_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= SEQ_IDLE;
      phase_q <= '0;
      idx_q   <= TOP_IDX;
      sar_q   <= '0;
      ser_q   <= 1'b1;
      stb_q   <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      sar_q   <= sar_d;
      ser_q   <= ser_d;
      stb_q   <= stb_d;
    end
  end

  assign running   = (state_q == SEQ_RUN);
  assign sar       = sar_q;
  assign dac_code  = running ? (sar_q | trial_mask) : sar_q;
  assign bit_stb   = stb_q;
  assign bit_val_n = ser_q;

endmodule

// File: rtl/sar_out_fmt.sv
module sar_out_fmt #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] sar,
  input  logic             msb_flip,
  input  logic             running,
  input  logic             bit_stb,
  input  logic             bit_val_n,
  output logic [WIDTH-1:0] data_n,
  output logic             ser_data,
  output logic             ser_clk,
  output logic             status
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign data_n[i] = ~sar[i] ^ msb_flip;
    end else begin : g_low
      assign data_n[i] = ~sar[i];
    end
  end

  assign ser_data = bit_val_n;
  assign ser_clk  = bit_stb;
  // status covers the trials plus the cycle that carries the last serial bit
  assign status   = running | bit_stb;

endmodule

// File: rtl/sar_convert_ctrl.sv
module sar_convert_ctrl #(
  parameter int WIDTH     = 16,
  parameter int MIN_RES   = 12,
  parameter int MIN_HIGH  = 2,
  parameter int TRIAL_CYC = 4,
  localparam int TRIM_W   = $clog2(WIDTH - MIN_RES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convert,
  input  logic [TRIM_W-1:0] res_trim,
  input  logic              msb_flip,
  input  logic              comp_in,
  output logic [WIDTH-1:0]  dac_code,
  output logic [WIDTH-1:0]  data_n,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              status
);

  localparam int IDX_W = $clog2(WIDTH);

  logic             rst_sync_n;
  logic             start, hold;
  logic [IDX_W-1:0] stop_idx;
  logic [WIDTH-1:0] sar;
  logic             running, bit_stb, bit_val_n;

  sar_start_ctl #(
    .WIDTH    (WIDTH),
    .MIN_RES  (MIN_RES),
    .MIN_HIGH (MIN_HIGH)
  ) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .convert    (convert),
    .res_trim   (res_trim),
    .rst_sync_n (rst_sync_n),
    .start      (start),
    .hold       (hold),
    .stop_idx   (stop_idx)
  );

  sar_trial_engine #(
    .WIDTH     (WIDTH),
    .TRIAL_CYC (TRIAL_CYC)
  ) u_engine (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .start      (start),
    .hold       (hold),
    .stop_idx   (stop_idx),
    .comp_in    (comp_in),
    .sar        (sar),
    .dac_code   (dac_code),
    .running    (running),
    .bit_stb    (bit_stb),
    .bit_val_n  (bit_val_n)
  );

  sar_out_fmt #(
    .WIDTH (WIDTH)
  ) u_fmt (
    .sar       (sar),
    .msb_flip  (msb_flip),
    .running   (running),
    .bit_stb   (bit_stb),
    .bit_val_n (bit_val_n),
    .data_n    (data_n),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .status    (status)
  );

endmodule

// File: rtl/sar_convert_ctrl_chk.sv
module sar_convert_ctrl_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             convert,
  input logic             msb_flip,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] data_n,
  input logic             ser_clk,
  input logic             status
);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    convert |=> !status);

  p_hold_dac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    convert |=> (dac_code == '0));

  p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> (!$past(convert) && $past(convert, 2)));

  p_ser_in_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> status);

  p_ser_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |=> !ser_clk);

  p_end_after_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status) && !$past(convert)) |-> $past(ser_clk));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && !$past(status) && !convert && !$past(convert) && $stable(msb_flip))
      |-> $stable(data_n));

endmodule

bind sar_convert_ctrl sar_convert_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .convert  (convert),
  .msb_flip (msb_flip),
  .dac_code (dac_code),
  .data_n   (data_n),
  .ser_clk  (ser_clk),
  .status   (status)
);

// File: tb/sim_sar_convert_ctrl.sv
module sim_sar_convert_ctrl;

  localparam int W  = 16;
  localparam int BC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        convert;
  logic [2:0]  res_trim;
  logic        msb_flip;
  logic        comp_in;
  logic [15:0] dac_code, data_n;
  logic        ser_data, ser_clk, status;
  logic [15:0] vin;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // ideal comparator: input at or above the DAC level
  assign comp_in = (vin >= dac_code);

  sar_convert_ctrl u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .convert  (convert),
    .res_trim (res_trim),
    .msb_flip (msb_flip),
    .comp_in  (comp_in),
    .dac_code (dac_code),
    .data_n   (data_n),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .status   (status)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_trim(input int t);
    return (t > 4) ? 4 : t;
  endfunction

  function automatic logic [15:0] ideal(input logic [15:0] v, input int t);
    logic [15:0] m;
    m = ~((16'd1 << eff_trim(t)) - 16'd1);
    return v & m;
  endfunction

  task automatic launch(input logic [15:0] v, input int trim, input bit flip);
    vin      = v;
    res_trim = 3'(trim);
    msb_flip = flip;
    convert  = 1'b1;
    repeat (3) @(negedge clk);
    convert = 1'b0;
    @(negedge clk);
    chk(status === 1'b1, "R2 status rises after convert falls", 32'(status), 1);
  endtask

  task automatic finish(input logic [15:0] v, input int trim, input bit flip, input bit late_trim);
    int          cyc = 0;
    int          nser = 0;
    logic [15:0] sbits = '0;
    logic [15:0] res;
    logic [15:0] nmask;
    int          n;
    n     = W - eff_trim(trim);
    res   = ideal(v, trim);
    nmask = 16'((32'd1 << n) - 1);
    while (status === 1'b1 && cyc < 300) begin
      if (cyc == 5 && late_trim) res_trim = 3'd4;
      if (ser_clk === 1'b1) begin
        sbits = {sbits[14:0], ser_data};
        nser++;
      end
      cyc++;
      @(negedge clk);
    end
    chk(cyc == n * BC + 1, "R4 status length", 32'(cyc), 32'(n * BC + 1));
    chk(nser == n, "R8 serial pulse count", 32'(nser), 32'(n));
    chk((sbits & nmask) == ((~(res >> eff_trim(trim))) & nmask),
        late_trim ? "R9 R8 serial bits after late trim" : "R8 serial bits",
        32'(sbits & nmask), 32'((~(res >> eff_trim(trim))) & nmask));
    chk(data_n == (~res ^ {flip, 15'd0}),
        late_trim ? "R9 R5 R6 parallel after late trim" : "R5 R6 R7 parallel result",
        32'(data_n), 32'(~res ^ {flip, 15'd0}));
  endtask

  task automatic t_reset();
    rst_n    = 1'b0;
    convert  = 1'b0;
    res_trim = '0;
    msb_flip = 1'b0;
    vin      = '0;
    repeat (3) @(negedge clk);
    chk(status === 1'b0 && ser_clk === 1'b0, "R1 status/ser_clk in reset", 32'({status, ser_clk}), 0);
    chk(ser_data === 1'b1, "R1 ser_data in reset", 32'(ser_data), 1);
    chk(data_n === 16'hffff && dac_code === 16'h0, "R1 parallel/dac in reset",
        32'({data_n, dac_code}), 32'hffff0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(status === 1'b0 && data_n === 16'hffff, "R1 idle after release", 32'({status, data_n}), 32'hffff);
  endtask

  task automatic t_sweep();
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] v;
        v = (k == 0) ? 16'hffff : (k == 1) ? 16'h0000 : 16'($urandom());
        launch(v, t, k[0]);
        finish(v, t, k[0], 1'b0);
      end
    end
    for (int k = 0; k < 6; k++) begin
      logic [15:0] v;
      v = 16'($urandom());
      launch(v, 0, 1'b0);
      finish(v, 0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_short_pulse();
    bit seen = 1'b0;
    @(negedge clk);
    convert = 1'b1;
    @(negedge clk);
    convert = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (status !== 1'b0) seen = 1'b1;
    end
    chk(!seen, "R2 short pulse ignored", 32'(seen), 0);
    chk(data_n === 16'hffff, "R3 short pulse still clears", 32'(data_n), 32'hffff);
  endtask

  task automatic t_abort();
    launch(16'h5a3c, 0, 1'b0);
    repeat (30) @(negedge clk);
    chk(status === 1'b1, "R4 still converting mid-way", 32'(status), 1);
    convert = 1'b1;
    @(negedge clk);
    chk(status === 1'b0, "R3 abort drops status", 32'(status), 0);
    chk(dac_code === 16'h0, "R3 abort clears dac", 32'(dac_code), 0);
    chk(data_n === 16'hffff, "R3 abort clears result", 32'(data_n), 32'hffff);
    launch(16'hc3a5, 0, 1'b0);
    finish(16'hc3a5, 0, 1'b0, 1'b0);
  endtask

  task automatic t_late_trim();
    launch(16'hbeef, 0, 1'b0);
    finish(16'hbeef, 0, 1'b0, 1'b1);
  endtask

  task automatic t_hold_flip();
    launch(16'h7531, 2, 1'b0);
    finish(16'h7531, 2, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk(data_n === ~ideal(16'h7531, 2), "R10 result held", 32'(data_n), 32'(~ideal(16'h7531, 2)));
    chk(dac_code === ideal(16'h7531, 2), "R10 R5 dac shows result", 32'(dac_code), 32'(ideal(16'h7531, 2)));
    msb_flip = 1'b1;
    @(negedge clk);
    chk(data_n === (~ideal(16'h7531, 2) ^ 16'h8000), "R7 live msb flip", 32'(data_n),
        32'(~ideal(16'h7531, 2) ^ 16'h8000));
    msb_flip = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_short_pulse();
    t_sweep();
    t_abort();
    t_late_trim();
    t_hold_flip();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule